// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block turns the addressing bytes of a memory-operand instruction into an effective offset. After the fetch unit has the addressing-form byte, it pulses `start` together with that byte and the address-size selection. The block then takes the optional scale/index/base byte and any displacement bytes from a byte stream, one per cycle while `byte_valid` is high. When it has every byte it needs, it shows the offset for one cycle. With the offset come a flag that makes the stack segment, and not the data segment, the default, and the number of bytes it took from the stream, so the fetch unit knows how far to advance.

Two addressing tables exist. The 16-bit table forms sums of pairs of low register halves, and every result wraps at 64 KiB. The 32-bit table uses any register directly, or an extra scale/index/base byte. Special codes stand for "no base register, use an immediate" or "no index". Register-direct operands (mode field 3), the register file and segment overrides are handled elsewhere.

The sequencer has four states. IDLE waits for `start`. SIB_WAIT takes the scale/index/base byte. DISP_WAIT gathers displacement bytes, lowest byte first. SHOW presents the result for exactly one cycle. The transitions are:
- IDLE->SIB_WAIT on start with a 32-bit form that has rm=4.
- IDLE->DISP_WAIT on start when a displacement is needed and no SIB byte is.
- IDLE->SHOW on start when no further bytes are needed.
- SIB_WAIT->DISP_WAIT or SIB_WAIT->SHOW once the byte arrives, depending on whether a displacement follows.
- DISP_WAIT->SHOW on the last displacement byte.
- SHOW->IDLE always.

Top module: `ea_gen`

## Requirements
- R1: On `start` in IDLE the block captures `modrm_in` (mode in bits 7:6, reg in 5:3, rm in 2:0) and `addr32_in`. A `start` that arrives in any other state is ignored.
- R2: In 16-bit mode the rm code picks a base as follows (register n sits at `regs_in[32n+31:32n]`; indices 0..7 are A,C,D,B,SP,BP,SI,DI; only the low 16 bits count): 0=BX+SI, 1=BX+DI, 2=BP+SI, 3=BP+DI, 4=SI, 5=DI, 6=BP, 7=BX.
- R3: In 16-bit mode with mode 0 and rm 6, no register is used and the offset is a 2-byte displacement.
- R4: Mode 1 adds one displacement byte, sign-extended. Mode 2 adds a 2-byte displacement in 16-bit mode and a 4-byte displacement in 32-bit mode. Displacement bytes arrive least significant first.
- R5: Every 16-bit result wraps modulo 65536, and bits 31:16 of `ea` are 0.
- R6: In 16-bit mode `ss_default` is 1 exactly for rm 2 and 3, and for rm 6 when the mode is not 0.
- R7: In 32-bit mode, rm values other than 4 select register rm as the base. With mode 0 and rm 5 there is no base and the offset is a 4-byte displacement.
- R8: In 32-bit mode rm=4 takes a SIB byte: scale in bits 7:6 (multiplier 1<<scale), index in 5:3, base in 2:0. Index code 4 means no index. The sum wraps modulo 2^32.
- R9: A SIB base code of 5 with mode 0 uses no base register and adds a 4-byte displacement.
- R10: In 32-bit mode `ss_default` is 1 for rm 5 with mode 1 or 2, for SIB base 4, and for SIB base 5 with mode 1 or 2. Otherwise it is 0.
- R11: `byte_count` equals the displacement length (0, 1, 2 or 4) plus 1 when a SIB byte was taken. The SIB byte is taken before any displacement byte.
- R12: After reset and outside SHOW, `done`, `ea`, `ss_default` and `byte_count` are 0. `done` is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding with `modrm_in` |
| modrm_in | input | 8 | Addressing-form byte |
| addr32_in | input | 1 | 1 selects the 32-bit addressing table |
| regs_in | input | 256 | Eight 32-bit general register values, register n at bits 32n+31:32n |
| byte_valid | input | 1 | A stream byte is present on `byte_in` |
| byte_in | input | 8 | Next instruction stream byte |
| done | output | 1 | Result valid this cycle |
| ea | output | 32 | Effective offset |
| ss_default | output | 1 | Default segment is the stack segment |
| byte_count | output | 3 | Bytes taken from the stream after the addressing-form byte |

## Verification
The assertions assume that `modrm_in` never carries mode 3, that `regs_in` stays stable from `start` until `done`, and that `byte_valid` is raised only while the block is collecting bytes. The bench keeps to these assumptions. It drives each case as a single `start` followed by exactly the computed number of stream bytes on consecutive cycles. It holds the register values constant for the whole case and uses mode values 0 to 2 only. One extra `start`, carrying a different addressing byte, is driven while bytes are still being collected, to show that it is ignored.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SIB_WAIT = 2'd1,
        ST_DISP_WAIT = 2'd2,
        ST_SHOW     = 2'd3
    } ea_state_e;

    localparam logic [1:0] MD_NODISP = 2'd0;
    localparam logic [1:0] MD_DISP8  = 2'd1;
    localparam logic [1:0] MD_DISPW  = 2'd2;
endpackage

// File: rtl/ea_gen_fsm.sv
module ea_gen_fsm
    import ea_gen_pkg::*;
#(
    parameter int DISP_BYTES = 4,
    parameter int CNT_W      = $clog2(DISP_BYTES + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [7:0]              modrm_in,
    input  logic                    addr32_in,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_in,
    output logic                    show,
    output logic                    busy,
    output logic [7:0]              modrm_q,
    output logic                    mode32_q,
    output logic [7:0]              sib_q,
    output logic                    has_sib_q,
    output logic [DISP_BYTES*8-1:0] disp_q,
    output logic [CNT_W-1:0]        len_q
);
    localparam logic [CNT_W-1:0] WIDE16 = CNT_W'(2);
    localparam logic [CNT_W-1:0] WIDE32 = CNT_W'(DISP_BYTES);

    ea_state_e         state, nxt;
    logic [CNT_W-1:0]  got_q;
    logic [CNT_W-1:0]  len_start, len_sib;
    logic              sib_needed;

    function automatic logic [CNT_W-1:0] disp_len(input logic m32,
                                                  input logic [1:0] md,
                                                  input logic no_base);
        logic [CNT_W-1:0] wide;
        wide = m32 ? WIDE32 : WIDE16;
        if (md == MD_DISP8)                     return CNT_W'(1);
        else if (md == MD_DISPW)                return wide;
        else if (md == MD_NODISP && no_base)    return wide;
        else                                    return '0;
    endfunction

    assign sib_needed = addr32_in && (modrm_in[2:0] == 3'd4);
    assign len_start  = disp_len(addr32_in, modrm_in[7:6],
                                 addr32_in ? (modrm_in[2:0] == 3'd5)
                                           : (modrm_in[2:0] == 3'd6));
    assign len_sib    = disp_len(1'b1, modrm_q[7:6], byte_in[2:0] == 3'd5);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (sib_needed)              nxt = ST_SIB_WAIT;
                    else if (len_start != '0)    nxt = ST_DISP_WAIT;
                    else                         nxt = ST_SHOW;
                end
            end
            ST_SIB_WAIT: begin
                if (byte_valid)
                    nxt = (len_sib != '0) ? ST_DISP_WAIT : ST_SHOW;
            end
            ST_DISP_WAIT: begin
                if (byte_valid && (got_q == len_q - CNT_W'(1)))
                    nxt = ST_SHOW;
            end
            ST_SHOW:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // byte capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            modrm_q   <= '0;
            mode32_q  <= 1'b0;
            sib_q     <= '0;
            has_sib_q <= 1'b0;
            disp_q    <= '0;
            len_q     <= '0;
            got_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        modrm_q   <= modrm_in;
                        mode32_q  <= addr32_in;
                        sib_q     <= '0;
                        has_sib_q <= sib_needed;
                        disp_q    <= '0;
                        len_q     <= sib_needed ? '0 : len_start;
                        got_q     <= '0;
                    end
                end
                ST_SIB_WAIT: begin
                    if (byte_valid) begin
                        sib_q <= byte_in;
                        len_q <= len_sib;
                    end
                end
                ST_DISP_WAIT: begin
                    if (byte_valid) begin
                        disp_q[{got_q, 3'b000} +: 8] <= byte_in;
                        got_q <= got_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // state-derived outputs
    always_comb begin
        show = (state == ST_SHOW);
        busy = (state != ST_IDLE);
    end
endmodule

// File: rtl/ea_gen_calc16.sv
module ea_gen_calc16 (
    input  logic [1:0]  md,
    input  logic [2:0]  rm,
    input  logic [15:0] bx,
    input  logic [15:0] bp,
    input  logic [15:0] si,
    input  logic [15:0] di,
    input  logic [15:0] disp,
    output logic [15:0] ea16,
    output logic        ss16
);
    logic [15:0] a, b, dx;

    always_comb begin
        a = '0;
        b = '0;
        unique case (rm)
            3'd0: begin a = bx; b = si; end
            3'd1: begin a = bx; b = di; end
            3'd2: begin a = bp; b = si; end
            3'd3: begin a = bp; b = di; end
            3'd4: a = si;
            3'd5: a = di;
            3'd6: a = (md == 2'd0) ? 16'd0 : bp;
            3'd7: a = bx;
            default: ;
        endcase
        dx   = (md == 2'd1) ? {{8{disp[7]}}, disp[7:0]} : disp;
        ea16 = a + b + dx;
        ss16 = (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && (md != 2'd0));
    end
endmodule

// File: rtl/ea_gen_calc32.sv
module ea_gen_calc32 #(
    parameter int NREG  = 8,
    parameter int REG_W = 32
) (
    input  logic [NREG-1:0][REG_W-1:0] regs,
    input  logic [1:0]                 md,
    input  logic [2:0]                 rm,
    input  logic [7:0]                 sib,
    input  logic [REG_W-1:0]           disp,
    output logic [REG_W-1:0]           ea32,
    output logic                       ss32
);
    logic [REG_W-1:0] base, idx, dx;
    logic [2:0]       sb;

    always_comb begin
        sb  = sib[2:0];
        idx = '0;
        dx  = (md == 2'd1) ? {{(REG_W-8){disp[7]}}, disp[7:0]} : disp;
        if (rm == 3'd4) begin
            base = ((md == 2'd0) && (sb == 3'd5)) ? '0 : regs[sb];
            idx  = (sib[5:3] == 3'd4) ? '0 : (regs[sib[5:3]] << sib[7:6]);
            ss32 = (sb == 3'd4) || ((sb == 3'd5) && (md != 2'd0));
        end else begin
            base = ((md == 2'd0) && (rm == 3'd5)) ? '0 : regs[rm];
            ss32 = (rm == 3'd5) && (md != 2'd0);
        end
        ea32 = base + idx + dx;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int REG_W      = 32,
    parameter int DISP_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [7:0]            modrm_in,
    input  logic                  addr32_in,
    input  logic [NREG*REG_W-1:0] regs_in,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_in,
    output logic                  done,
    output logic [REG_W-1:0]      ea,
    output logic                  ss_default,
    output logic [2:0]            byte_count
);
    localparam int CNT_W = $clog2(DISP_BYTES + 2);

    logic [NREG-1:0][REG_W-1:0] regs;
    logic                       show, busy, mode32_q, has_sib_q, ss16, ss32;
    logic [7:0]                 modrm_q, sib_q;
    logic [DISP_BYTES*8-1:0]    disp_q;
    logic [CNT_W-1:0]           len_q;
    logic [15:0]                ea16;
    logic [REG_W-1:0]           ea32;

    assign regs = regs_in;

    ea_gen_fsm #(.DISP_BYTES(DISP_BYTES), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .modrm_in(modrm_in),
        .addr32_in(addr32_in), .byte_valid(byte_valid), .byte_in(byte_in),
        .show(show), .busy(busy), .modrm_q(modrm_q), .mode32_q(mode32_q),
        .sib_q(sib_q), .has_sib_q(has_sib_q), .disp_q(disp_q), .len_q(len_q)
    );

    ea_gen_calc16 u_c16 (
        .md(modrm_q[7:6]), .rm(modrm_q[2:0]),
        .bx(regs[3][15:0]), .bp(regs[5][15:0]),
        .si(regs[6][15:0]), .di(regs[7][15:0]),
        .disp(disp_q[15:0]), .ea16(ea16), .ss16(ss16)
    );

    ea_gen_calc32 #(.NREG(NREG), .REG_W(REG_W)) u_c32 (
        .regs(regs), .md(modrm_q[7:6]), .rm(modrm_q[2:0]), .sib(sib_q),
        .disp(REG_W'(disp_q)), .ea32(ea32), .ss32(ss32)
    );

    always_comb begin
        done       = show;
        ea         = '0;
        ss_default = 1'b0;
        byte_count = '0;
        if (show) begin
            ea         = mode32_q ? ea32 : REG_W'(ea16);
            ss_default = mode32_q ? ss32 : ss16;
            byte_count = 3'(len_q) + 3'(has_sib_q);
        end
    end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic [REG_W-1:0] ea,
    input logic             ss_default,
    input logic [2:0]       byte_count,
    input logic             mode32_q,
    input logic             busy,
    input logic [7:0]       modrm_q
);
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (ea == '0 && !ss_default && byte_count == 3'd0));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode32_q) |-> (ea[REG_W-1:16] == '0));

    a_r11_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_count <= 3'd5 && byte_count != 3'd3));

    a_r11_count16: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode32_q) |-> (byte_count <= 3'd2));

    a_r1_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(modrm_q));
endmodule

bind ea_gen ea_gen_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   modrm_in = '0;
    logic         addr32_in = 1'b0;
    logic [255:0] regs_in;
    logic         byte_valid = 1'b0;
    logic [7:0]   byte_in = '0;
    logic         done;
    logic [31:0]  ea;
    logic         ss_default;
    logic [2:0]   byte_count;

    logic [31:0]  rf [8];
    int           n_chk = 0;
    int           n_bad = 0;
    int           cyc = 0;

    always #10 clk = ~clk;

    assign regs_in = {rf[7], rf[6], rf[5], rf[4], rf[3], rf[2], rf[1], rf[0]};

    ea_gen dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic m32, input logic [7:0] mr,
                                  input logic [7:0] sb, input logic [31:0] dv,
                                  output logic [31:0] e, output logic s,
                                  output int dl, output logic sp);
        logic [1:0]  md;
        logic [2:0]  rm;
        logic [31:0] dm, dx, b, x;
        logic [15:0] bx, bp, si, di, a16, b16;
        md = mr[7:6];
        rm = mr[2:0];
        sp = m32 && rm == 3'd4;
        if (!m32) begin
            dl = (md == 2'd1) ? 1 : (md == 2'd2) ? 2 : (md == 2'd0 && rm == 3'd6) ? 2 : 0;
        end else if (sp) begin
            dl = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 : (md == 2'd0 && sb[2:0] == 3'd5) ? 4 : 0;
        end else begin
            dl = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 : (md == 2'd0 && rm == 3'd5) ? 4 : 0;
        end
        dm = (dl == 0) ? 32'd0 : (dl == 1) ? {24'd0, dv[7:0]} :
             (dl == 2) ? {16'd0, dv[15:0]} : dv;
        dx = (md == 2'd1) ? {{24{dm[7]}}, dm[7:0]} : dm;
        if (!m32) begin
            bx = rf[3][15:0]; bp = rf[5][15:0]; si = rf[6][15:0]; di = rf[7][15:0];
            a16 = 16'd0; b16 = 16'd0;
            case (rm)
                3'd0: begin a16 = bx; b16 = si; end
                3'd1: begin a16 = bx; b16 = di; end
                3'd2: begin a16 = bp; b16 = si; end
                3'd3: begin a16 = bp; b16 = di; end
                3'd4: a16 = si;
                3'd5: a16 = di;
                3'd6: a16 = (md == 2'd0) ? 16'd0 : bp;
                default: a16 = bx;
            endcase
            e = {16'd0, 16'(a16 + b16 + dx[15:0])};
            s = (rm == 3'd2 || rm == 3'd3 || (rm == 3'd6 && md != 2'd0));
        end else if (sp) begin
            b = (md == 2'd0 && sb[2:0] == 3'd5) ? 32'd0 : rf[sb[2:0]];
            x = (sb[5:3] == 3'd4) ? 32'd0 : rf[sb[5:3]] * (32'd1 << sb[7:6]);
            e = b + x + dx;
            s = (sb[2:0] == 3'd4) || (sb[2:0] == 3'd5 && md != 2'd0);
        end else begin
            b = (md == 2'd0 && rm == 3'd5) ? 32'd0 : rf[rm];
            e = b + dx;
            s = (rm == 3'd5 && md != 2'd0);
        end
    endfunction

    task automatic run_case(input string tag, input logic m32, input logic [7:0] mr,
                            input logic [7:0] sb, input logic [31:0] dv, input bit poke);
        logic [31:0] e;
        logic        s, sp;
        int          dl, n, w;
        logic [7:0]  bl [6];
        model(m32, mr, sb, dv, e, s, dl, sp);
        n = 0;
        if (sp) begin bl[n] = sb; n++; end
        for (int i = 0; i < dl; i++) begin bl[n] = dv[8*i +: 8]; n++; end
        @(negedge clk);
        start = 1'b1; modrm_in = mr; addr32_in = m32;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (poke && i == 0) begin
                start = 1'b1; modrm_in = ~mr & 8'h3F; addr32_in = ~m32;
            end
            byte_valid = 1'b1; byte_in = bl[i];
            @(negedge clk);
            start = 1'b0;
        end
        byte_valid = 1'b0; byte_in = '0;
        w = 0;
        while (!done && w < 10) begin @(negedge clk); w++; end
        chk(tag, "done", {31'd0, done}, 32'd1);
        chk(tag, "ea", ea, e);
        chk(tag, "ss_default", {31'd0, ss_default}, {31'd0, s});
        chk(tag, "byte_count", {29'd0, byte_count}, 32'(n));
        @(negedge clk);
        chk("R12", "done fall", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R12", "reset done", {31'd0, done}, 32'd0);
        chk("R12", "reset ea", ea, 32'd0);
        chk("R12", "reset count", {29'd0, byte_count}, 32'd0);
    endtask

    task automatic t_rows16;   // R2
        for (int r = 0; r < 8; r++) run_case("R2", 1'b0, 8'(r), 8'h00, 32'h0000_1234, 1'b0);
    endtask

    task automatic t_direct16; // R3
        run_case("R3", 1'b0, 8'h06, 8'h00, 32'h0000_BEEF, 1'b0);
        run_case("R3", 1'b0, 8'h3E, 8'h00, 32'h0000_0002, 1'b0);
    endtask

    task automatic t_disp_sizes; // R4
        run_case("R4", 1'b0, 8'h47, 8'h00, 32'h0000_0080, 1'b0);
        run_case("R4", 1'b0, 8'h84, 8'h00, 32'h0000_9000, 1'b0);
        run_case("R4", 1'b1, 8'h41, 8'h00, 32'h0000_00F0, 1'b0);
        run_case("R4", 1'b1, 8'h82, 8'h00, 32'h8000_0001, 1'b0);
    endtask

    task automatic t_wrap16;   // R5
        rf[3] = 32'hABCD_FFF0; rf[6] = 32'h0000_0030;
        run_case("R5", 1'b0, 8'h40, 8'h00, 32'h0000_007F, 1'b0);
        run_case("R5", 1'b0, 8'h80, 8'h00, 32'h0000_FFFF, 1'b0);
        rf[3] = 32'h0000_4321; rf[6] = 32'h0000_0011;
    endtask

    task automatic t_bp16;     // R6
        run_case("R6", 1'b0, 8'h42, 8'h00, 32'h0000_0005, 1'b0);
        run_case("R6", 1'b0, 8'h83, 8'h00, 32'h0000_0100, 1'b0);
        run_case("R6", 1'b0, 8'h46, 8'h00, 32'h0000_00FE, 1'b0);
        run_case("R6", 1'b0, 8'h06, 8'h00, 32'h0000_0F00, 1'b0);
    endtask

    task automatic t_rows32;   // R7
        for (int r = 0; r < 8; r++) begin
            if (r != 4) begin
                run_case("R7", 1'b1, 8'(r), 8'h00, 32'h1234_5678, 1'b0);
                run_case("R7", 1'b1, 8'h80 | 8'(r), 8'h00, 32'h0000_0100, 1'b0);
            end
        end
    endtask

    task automatic t_sib;      // R8
        run_case("R8", 1'b1, 8'h04, 8'h08, 32'h0, 1'b0);
        run_case("R8", 1'b1, 8'h04, 8'h51, 32'h0, 1'b0);
        run_case("R8", 1'b1, 8'h44, 8'hBA, 32'h0000_0090, 1'b0);
        run_case("R8", 1'b1, 8'h04, 8'hE3, 32'h0, 1'b0);
        run_case("R8", 1'b1, 8'h04, 8'hF0, 32'h0, 1'b0);
    endtask

    task automatic t_sib_nobase; // R9
        run_case("R9", 1'b1, 8'h04, 8'h25, 32'hCAFE_0000, 1'b0);
        run_case("R9", 1'b1, 8'h04, 8'h75, 32'h0000_1000, 1'b0);
    endtask

    task automatic t_ss32;     // R10
        run_case("R10", 1'b1, 8'h45, 8'h00, 32'h0000_0010, 1'b0);
        run_case("R10", 1'b1, 8'h05, 8'h00, 32'h0000_2000, 1'b0);
        run_case("R10", 1'b1, 8'h04, 8'h24, 32'h0, 1'b0);
        run_case("R10", 1'b1, 8'h84, 8'h0D, 32'h0000_0400, 1'b0);
        run_case("R10", 1'b1, 8'h43, 8'h00, 32'h0000_0001, 1'b0);
    endtask

    task automatic t_count;    // R11
        run_case("R11", 1'b1, 8'h84, 8'h30, 32'h0102_0304, 1'b0);
        run_case("R11", 1'b1, 8'h44, 8'h30, 32'h0000_00FF, 1'b0);
        run_case("R11", 1'b0, 8'h07, 8'h00, 32'h0, 1'b0);
    endtask

    task automatic t_busy;     // R1
        run_case("R1", 1'b1, 8'h82, 8'h00, 32'h0000_4444, 1'b1);
        run_case("R1", 1'b0, 8'h81, 8'h00, 32'h0000_0777, 1'b1);
    endtask

    initial begin
        rf[0] = 32'h1000_0100; rf[1] = 32'h2000_0200; rf[2] = 32'h3000_0300;
        rf[3] = 32'h0000_4321; rf[4] = 32'h0000_8000; rf[5] = 32'h0000_0F00;
        rf[6] = 32'h0000_0011; rf[7] = 32'h0000_0022;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rows16();
        t_direct16();
        t_disp_sizes();
        t_wrap16();
        t_bp16();
        t_rows32();
        t_sib();
        t_sib_nobase();
        t_ss32();
        t_count();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule